// File: doc/BRIEF.md
# Character LCD Nibble Controller

This block drives a character display module over a four-bit data path with separate register-select, read/write and enable lines. After reset it runs the display's wake-up routine on its own. The routine starts with a power-up wait and four single-nibble writes with their own waits. It then sends five full configuration bytes: function set to four bits and two lines, display off, clear, entry mode increment, and display on with no cursor.

When the routine is finished, a client hands over one byte at a time on a valid/ready handshake. Each byte can be a command write, a character write, a status read or a data read. The controller splits every byte into two strobed nibble transfers, high nibble first. For reads it releases the data pins and joins the two returned nibbles into one byte. All timing is counted in ticks of 20 µs. A parameterised divider of the system clock produces the tick.

Top module: `charlcd_nibble_ctrl`

## Requirements
- R1: One tick is CLK_PER_TICK clock cycles. Every strobe keeps `lcd_en` high for at least one tick, and `lcd_rs`/`lcd_rw` are settled at least one tick before `lcd_en` rises and stay unchanged while it is high.
- R2: After reset, no strobe happens before PWRUP_TICKS ticks. The first four strobes carry the nibbles 0x3, 0x3, 0x3, 0x2 with `lcd_rs`=0 and `lcd_rw`=0. They are followed by waits of at least WAKE1_TICKS, WAKE2_TICKS, GAP_TICKS and GAP_TICKS ticks.
- R3: The wake-up nibbles are followed by the command bytes 0x28, 0x08, 0x01, 0x06, 0x0C, each sent as two nibbles.
- R4: `req_ready` is 0 from reset until the wake-up routine ends and during every transfer. A request held valid meanwhile is accepted on the first cycle in which `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the following cycle.
- R5: Each byte is sent as its bits [7:4] first, then its bits [3:0]. Between two strobes there are at least GAP_TICKS ticks plus the setup and strobe ticks of the next nibble.
- R6: `lcd_rs` equals `req_rs` (0 for command write and status read, 1 for character write and data read), and `lcd_rw` equals `req_read` (1 for reads), for both nibbles of the transfer.
- R7: On a write, `lcd_db_oe` is 1 and `lcd_db_out` holds the nibble while `lcd_en` is high. On a read, `lcd_db_oe` is 0 while `lcd_en` is high.
- R8: A read samples `lcd_db_in` as `lcd_en` falls. After the second nibble, `rd_valid` pulses for one cycle with `rd_data` = first nibble × 16 + second nibble. Writes never raise `rd_valid`.
- R9: A command write (RS=0, RW=0) of 0x01, 0x02 or 0x03 (clear or home) is followed by at least CLEAR_TICKS ticks before the next strobe. Every other transfer waits GAP_TICKS ticks.
- R10: During reset, `lcd_en`=0, `req_ready`=0, `rd_valid`=0 and `lcd_db_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_rs | input | 1 | 0 = command/status, 1 = character/data |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_data | input | 8 | Byte to write (ignored on reads) |
| rd_valid | output | 1 | One-cycle pulse: read byte available |
| rd_data | output | 8 | Byte assembled from the two read nibbles |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write select |
| lcd_en | output | 1 | Display enable strobe |
| lcd_db_out | output | 4 | Nibble driven to the display data pins |
| lcd_db_oe | output | 1 | Output enable for the data pins |
| lcd_db_in | input | 4 | Nibble read back from the data pins |

## Verification
Two functions can overlap in time. A client request can be pending while the controller is still running its own wake-up routine. The read result of one access can also appear in the same cycle in which the controller becomes ready for the next access. The bench raises a character write in the first cycle after reset and keeps it valid through the whole wake-up routine. It then checks that the request waited at least the power-up time and that its nibbles appear on the bus only after the last wake-up byte. Back-to-back reads and writes are issued as soon as ready returns. Every strobe is compared in order against an expected list that the bench builds from the requirements, and every returned read byte is compared against the display model's contents.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

  typedef enum logic [1:0] {
    K_WAIT = 2'd0,
    K_NIB  = 2'd1,
    K_BYTE = 2'd2
  } step_kind_t;

  localparam int STEP_W     = 4;
  localparam int INIT_STEPS = 10;

  // wake-up routine: one idle wait, four single nibbles, five full bytes
  function automatic step_kind_t step_kind(input logic [STEP_W-1:0] idx);
    case (idx)
      4'd0:                         step_kind = K_WAIT;
      4'd1, 4'd2, 4'd3, 4'd4:       step_kind = K_NIB;
      default:                      step_kind = K_BYTE;
    endcase
  endfunction

  function automatic logic [7:0] step_value(input logic [STEP_W-1:0] idx);
    case (idx)
      4'd1, 4'd2, 4'd3: step_value = 8'h03;
      4'd4:             step_value = 8'h02;
      4'd5:             step_value = 8'h28;
      4'd6:             step_value = 8'h08;
      4'd7:             step_value = 8'h01;
      4'd8:             step_value = 8'h06;
      4'd9:             step_value = 8'h0C;
      default:          step_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/charlcd_tick_gen.sv
module charlcd_tick_gen #(
  parameter int CLK_PER_TICK = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(CLK_PER_TICK + 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(CLK_PER_TICK - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/charlcd_nibble_phy.sv
module charlcd_nibble_phy #(
  parameter int CLK_PER_TICK = 2000,
  parameter int TW           = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_nop,
  input  logic          op_rs,
  input  logic          op_rw,
  input  logic [3:0]    op_nib,
  input  logic [TW-1:0] op_gap,
  output logic          done,
  output logic [3:0]    rd_nib,
  output logic          lcd_rs,
  output logic          lcd_rw,
  output logic          lcd_en,
  output logic [3:0]    lcd_db_out,
  output logic          lcd_db_oe,
  input  logic [3:0]    lcd_db_in
);
  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_HIGH, P_GAP} phase_t;

  phase_t        phase;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] gap_q;
  logic          tick;
  logic          restart;

  assign restart = (phase == P_IDLE) && start;

  charlcd_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) tick_i (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= P_IDLE;
      tcnt       <= '0;
      gap_q      <= '0;
      done       <= 1'b0;
      rd_nib     <= 4'h0;
      lcd_rs     <= 1'b0;
      lcd_rw     <= 1'b0;
      lcd_en     <= 1'b0;
      lcd_db_out <= 4'h0;
      lcd_db_oe  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (phase)
        P_IDLE: if (start) begin
          gap_q <= op_gap;
          tcnt  <= '0;
          if (op_nop) begin
            phase <= P_GAP;
          end else begin
            lcd_rs     <= op_rs;
            lcd_rw     <= op_rw;
            lcd_db_oe  <= !op_rw;
            lcd_db_out <= op_rw ? 4'h0 : op_nib;
            phase      <= P_SETUP;
          end
        end
        P_SETUP: if (tick) begin
          lcd_en <= 1'b1;
          phase  <= P_HIGH;
        end
        P_HIGH: if (tick) begin
          lcd_en <= 1'b0;
          rd_nib <= lcd_db_in;
          phase  <= P_GAP;
        end
        P_GAP: if (tick) begin
          if (tcnt == gap_q - TW'(1)) begin
            phase <= P_IDLE;
            done  <= 1'b1;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/charlcd_nibble_ctrl.sv
module charlcd_nibble_ctrl
  import charlcd_pkg::*;
#(
  parameter int CLK_PER_TICK = 2000,
  parameter int PWRUP_TICKS  = 1000,
  parameter int WAKE1_TICKS  = 205,
  parameter int WAKE2_TICKS  = 5,
  parameter int GAP_TICKS    = 2,
  parameter int CLEAR_TICKS  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_read,
  input  logic [7:0] req_data,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [3:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [3:0] lcd_db_in
);
  localparam int MAX_A = (PWRUP_TICKS > CLEAR_TICKS) ? PWRUP_TICKS : CLEAR_TICKS;
  localparam int MAX_B = (MAX_A > WAKE1_TICKS) ? MAX_A : WAKE1_TICKS;
  localparam int TW    = $clog2(MAX_B + 1);

  typedef enum logic [1:0] {S_STEP, S_IDLE, S_HI, S_LO} state_t;

  state_t            state;
  logic [STEP_W-1:0] step;
  logic              issued;
  logic              from_init;
  logic [7:0]        cur_byte;
  logic              cur_rs;
  logic              cur_rw;
  logic [3:0]        hi_q;

  step_kind_t    kind;
  logic [7:0]    sval;
  logic          long_cmd;
  logic          phy_start;
  logic          phy_nop;
  logic [3:0]    phy_nib;
  logic [TW-1:0] phy_gap;
  logic          phy_rs;
  logic          phy_rw;
  logic          phy_done;
  logic [3:0]    phy_rd;

  assign kind      = step_kind(step);
  assign sval      = step_value(step);
  assign long_cmd  = !cur_rs && !cur_rw && (cur_byte[7:2] == 6'd0) && (cur_byte[1:0] != 2'd0);
  assign req_ready = (state == S_IDLE);

  always_comb begin
    phy_start = 1'b0;
    phy_nop   = 1'b0;
    phy_nib   = 4'h0;
    phy_rs    = cur_rs;
    phy_rw    = cur_rw;
    phy_gap   = TW'(GAP_TICKS);
    case (state)
      S_STEP: begin
        phy_start = !issued && (kind != K_BYTE);
        phy_nop   = (kind == K_WAIT);
        phy_nib   = sval[3:0];
        phy_rs    = 1'b0;
        phy_rw    = 1'b0;
        case (step)
          4'd0:    phy_gap = TW'(PWRUP_TICKS);
          4'd1:    phy_gap = TW'(WAKE1_TICKS);
          4'd2:    phy_gap = TW'(WAKE2_TICKS);
          default: phy_gap = TW'(GAP_TICKS);
        endcase
      end
      S_HI: begin
        phy_start = !issued;
        phy_nib   = cur_byte[7:4];
      end
      S_LO: begin
        phy_start = !issued;
        phy_nib   = cur_byte[3:0];
        phy_gap   = long_cmd ? TW'(CLEAR_TICKS) : TW'(GAP_TICKS);
      end
      default: ;
    endcase
  end

  charlcd_nibble_phy #(.CLK_PER_TICK(CLK_PER_TICK), .TW(TW)) phy_i (
    .clk        (clk),
    .rst        (rst),
    .start      (phy_start),
    .op_nop     (phy_nop),
    .op_rs      (phy_rs),
    .op_rw      (phy_rw),
    .op_nib     (phy_nib),
    .op_gap     (phy_gap),
    .done       (phy_done),
    .rd_nib     (phy_rd),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_en     (lcd_en),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe),
    .lcd_db_in  (lcd_db_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_STEP;
      step      <= '0;
      issued    <= 1'b0;
      from_init <= 1'b1;
      cur_byte  <= 8'h00;
      cur_rs    <= 1'b0;
      cur_rw    <= 1'b0;
      hi_q      <= 4'h0;
      rd_valid  <= 1'b0;
      rd_data   <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      if (phy_start) issued <= 1'b1;
      case (state)
        S_STEP: begin
          if (kind == K_BYTE) begin
            cur_byte  <= sval;
            cur_rs    <= 1'b0;
            cur_rw    <= 1'b0;
            from_init <= 1'b1;
            step      <= step + STEP_W'(1);
            state     <= S_HI;
          end else if (phy_done) begin
            issued <= 1'b0;
            step   <= step + STEP_W'(1);
          end
        end
        S_IDLE: if (req_valid) begin
          cur_byte  <= req_data;
          cur_rs    <= req_rs;
          cur_rw    <= req_read;
          from_init <= 1'b0;
          state     <= S_HI;
        end
        S_HI: if (phy_done) begin
          issued <= 1'b0;
          hi_q   <= phy_rd;
          state  <= S_LO;
        end
        S_LO: if (phy_done) begin
          issued <= 1'b0;
          if (cur_rw) begin
            rd_data  <= {hi_q, phy_rd};
            rd_valid <= 1'b1;
          end
          if (from_init && (step != STEP_W'(INIT_STEPS))) state <= S_STEP;
          else                                             state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/charlcd_nibble_ctrl_chk.sv
module charlcd_nibble_ctrl_chk #(
  parameter int CLK_PER_TICK = 2000
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_en,
  input logic [3:0] lcd_db_out,
  input logic       lcd_db_oe
);
  int   en_cnt;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)         en_cnt <= 0;
    else if (lcd_en) en_cnt <= en_cnt + 1;
    else             en_cnt <= 0;
  end

  // R10: outputs right after a reset edge
  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_state_r10: assert (!lcd_en && !req_ready && !rd_valid && lcd_db_oe)
        else $error("reset state wrong");
    end
  end

  // R1: enable pulse lasts at least one tick
  p_en_width_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> (en_cnt >= CLK_PER_TICK));

  // R1: select lines settled before the strobe rises
  p_setup_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

  // R7: bus contents frozen while the strobe is high
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_db_out) && $stable(lcd_rs) && $stable(lcd_rw)));

  // R7: bus direction follows the access type
  p_dir_read_r7: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && lcd_rw) |-> !lcd_db_oe);
  p_dir_write_r7: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && !lcd_rw) |-> lcd_db_oe);

  // R4: never ready while a strobe is in progress, busy after acceptance
  p_busy_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> !req_ready);
  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8: read result is a single-cycle pulse
  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

bind charlcd_nibble_ctrl charlcd_nibble_ctrl_chk #(.CLK_PER_TICK(CLK_PER_TICK)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .lcd_rs     (lcd_rs),
  .lcd_rw     (lcd_rw),
  .lcd_en     (lcd_en),
  .lcd_db_out (lcd_db_out),
  .lcd_db_oe  (lcd_db_oe)
);

// File: tb/charlcd_nibble_ctrl_tb_top.sv
module charlcd_nibble_ctrl_tb_top;
  localparam int D     = 4;
  localparam int PWR   = 1000;
  localparam int WAKE1 = 205;
  localparam int WAKE2 = 5;
  localparam int GAP   = 2;
  localparam int CLR   = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_rs = 1'b0;
  logic       req_read = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       lcd_rs, lcd_rw, lcd_en, lcd_db_oe;
  logic [3:0] lcd_db_out;
  logic [3:0] lcd_db_in = 4'h0;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int last_fall = 0;
  int rise_cyc  = 0;
  int prev_gap  = PWR;
  bit prev_long = 1'b0;
  bit done_flag = 1'b0;

  typedef struct packed {
    logic       rs;
    logic       rw;
    logic [3:0] nib;
    int         min_gap;
    logic       tight;
  } ev_t;

  ev_t        expq[$];
  string      tagq[$];
  logic [7:0] rdq[$];

  logic [7:0] mdl_byte = 8'h00;
  logic       mdl_half = 1'b0;
  logic       prev_en = 1'b0;
  logic       prev_rs = 1'b0;
  logic       prev_rw = 1'b0;
  logic       rise_rs = 1'b0;
  logic       rise_rw = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  charlcd_nibble_ctrl #(
    .CLK_PER_TICK(D), .PWRUP_TICKS(PWR), .WAKE1_TICKS(WAKE1),
    .WAKE2_TICKS(WAKE2), .GAP_TICKS(GAP), .CLEAR_TICKS(CLR)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_read(req_read), .req_data(req_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe),
    .lcd_db_in(lcd_db_in)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push_ev(input logic rs, input logic rw, input logic [3:0] nib,
                         input int gap_after, input logic tight, input string tag);
    ev_t e;
    e.rs      = rs;
    e.rw      = rw;
    e.nib     = nib;
    e.min_gap = (prev_gap + 2) * D;
    e.tight   = tight;
    expq.push_back(e);
    tagq.push_back(prev_long ? "R9" : tag);
    prev_long = (gap_after == CLR);
    prev_gap  = gap_after;
  endtask

  // R5 high nibble first; R9 long wait after clear/home commands
  task automatic push_byte(input logic rs, input logic rw, input logic [7:0] b,
                           input string tag);
    int post;
    post = (!rs && !rw && b >= 8'h01 && b <= 8'h03) ? CLR : GAP;
    push_ev(rs, rw, b[7:4], GAP, 1'b0, tag);
    push_ev(rs, rw, b[3:0], post, 1'b1, "R5");
  endtask

  task automatic send(input logic rs, input logic rd, input logic [7:0] b,
                      input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    push_byte(rs, rd, b, tag);
    if (rd) begin
      mdl_byte = b;
      mdl_half = 1'b0;
      rdq.push_back(b);
    end
    req_rs = rs; req_read = rd; req_data = rd ? 8'hA5 : b;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R4", "ready after accept", req_ready, 0);
  endtask

  // display model and bus monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (lcd_en && !prev_en) begin
        rise_cyc = cyc;
        rise_rs  = lcd_rs;
        rise_rw  = lcd_rw;
        chk(lcd_rs == prev_rs && lcd_rw == prev_rw, "R1", "select setup",
            {lcd_rs, lcd_rw}, {prev_rs, prev_rw});
        if (lcd_rw) lcd_db_in = mdl_half ? mdl_byte[3:0] : mdl_byte[7:4];
      end
      if (!lcd_en && prev_en) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5", "unexpected strobe", lcd_db_out, 0);
        end else begin
          ev_t   e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(lcd_rs == e.rs, "R6", "rs", lcd_rs, e.rs);
          chk(lcd_rw == e.rw, "R6", "rw", lcd_rw, e.rw);
          chk(rise_rs == lcd_rs && rise_rw == lcd_rw, "R1", "select stable", rise_rs, lcd_rs);
          chk(lcd_db_oe == !e.rw, "R7", "bus direction", lcd_db_oe, !e.rw);
          if (!e.rw) chk(lcd_db_out == e.nib, t, "nibble", lcd_db_out, e.nib);
          chk(cyc - rise_cyc >= D, "R1", "enable width", cyc - rise_cyc, D);
          chk(cyc - last_fall >= e.min_gap, t, "strobe spacing", cyc - last_fall, e.min_gap);
          if (e.tight)
            chk(cyc - last_fall <= e.min_gap + 4, "R5", "spacing upper", cyc - last_fall, e.min_gap + 4);
        end
        last_fall = cyc;
        if (lcd_rw) mdl_half = ~mdl_half;
      end
      if (rd_valid) begin
        if (rdq.size() == 0) chk(1'b0, "R8", "spurious rd_valid", rd_data, 0);
        else begin
          logic [7:0] x;
          x = rdq.pop_front();
          chk(rd_data == x, "R8", "read byte", rd_data, x);
        end
      end
    end
    prev_en = lcd_en;
    prev_rs = lcd_rs;
    prev_rw = lcd_rw;
  end

  always @(posedge clk) begin
    if (cyc == 190000 && !done_flag) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int waited;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(lcd_en == 1'b0, "R10", "en in reset", lcd_en, 0);
    chk(req_ready == 1'b0, "R10", "ready in reset", req_ready, 0);
    chk(rd_valid == 1'b0, "R10", "rd_valid in reset", rd_valid, 0);
    chk(lcd_db_oe == 1'b1, "R10", "oe in reset", lcd_db_oe, 1);
    rst = 1'b0;
    last_fall = cyc;
    // R2 wake-up nibbles, R3 configuration bytes
    push_ev(1'b0, 1'b0, 4'h3, WAKE1, 1'b0, "R2");
    push_ev(1'b0, 1'b0, 4'h3, WAKE2, 1'b1, "R2");
    push_ev(1'b0, 1'b0, 4'h3, GAP,   1'b1, "R2");
    push_ev(1'b0, 1'b0, 4'h2, GAP,   1'b1, "R2");
    push_byte(1'b0, 1'b0, 8'h28, "R3");
    push_byte(1'b0, 1'b0, 8'h08, "R3");
    push_byte(1'b0, 1'b0, 8'h01, "R3");
    push_byte(1'b0, 1'b0, 8'h06, "R3");
    push_byte(1'b0, 1'b0, 8'h0C, "R3");
    // R4 request held during wake-up
    push_byte(1'b1, 1'b0, 8'h41, "R4");
    req_rs = 1'b1; req_read = 1'b0; req_data = 8'h41; req_valid = 1'b1;
    waited = 0;
    @(negedge clk);
    while (!req_ready) begin
      waited++;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(waited >= PWR * D, "R4", "held until ready", waited, PWR * D);
    // R9 and R6: every command byte
    for (int i = 0; i < 256; i++) send(1'b0, 1'b0, 8'(i), "R6");
    // R6: every character byte
    for (int i = 0; i < 256; i++) send(1'b1, 1'b0, 8'(i), "R6");
    // R8: data reads of every value
    for (int i = 0; i < 256; i++) send(1'b1, 1'b1, 8'(i) ^ 8'h5A, "R8");
    // R8: status reads
    for (int i = 0; i < 16; i++) send(1'b0, 1'b1, 8'(i * 17), "R8");
    @(negedge clk);
    while (!req_ready || expq.size() != 0 || rdq.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule